// File: doc/BRIEF.md
# Idle-Locked Stream Cipher Descrambler

This block sits on the receive side of a serial link whose transmitter scrambles every bit by XORing it with the output of an 11-stage linear feedback shift register. The two taps are at stages 9 and 11. The descrambler has no seed from the transmitter, so it has to rebuild the scrambler state from the line. It uses the fact that the idle line state is all ones once the line coding is removed. In sample mode a hypothesis path predicts each received bit from the bits 9 and 11 positions earlier. If the data under the scramble is idle, the prediction combined with the received bit gives a one. After 50 such ones in a row the block enters hold mode and sets `locked`.

In hold mode a tracking register stops copying the line and runs free as a shift register with feedback. It stays aligned with the transmitter and descrambles any traffic, not only idle. A retriggerable hold timer is reloaded by each run of ten descrambled ones. When the timer runs out, the block drops back to sample mode. Losing clock-detect or signal-detect also forces sample mode at once.

A 2-bit mode input chooses the line coding on each side. Either side can be NRZ or NRZI, and a fourth setting passes bits through untouched. One descrambled bit leaves one clock after each accepted input bit, with a valid strobe.

Top module: `idle_lock_descrambler`

## Requirements
- R1: During and directly after reset, `locked`, `out_valid` and `out_bit` are 0.
- R2: The mode input selects the coding. 2'b00 means NRZI line input and NRZI output. 2'b01 means NRZ line input and NRZI output. 2'b10 means NRZ on both sides. In NRZI a 1 is a change of level and a 0 is no change, and both NRZI state bits start at 0 after reset.
- R3: In sample mode the hypothesis bit is the NRZ line bit XOR the line bits received 9 and 11 bits earlier. `locked` rises on the clock edge that accepts the 50th consecutive hypothesis bit equal to 1, and not before.
- R4: Line data whose plain content is not all ones, such as all zeros or a repeating `11000` symbol, never sets `locked`.
- R5: While locked, the output carries the plain data. In NRZ output that is `out_bit` itself, and in NRZI output it is the change of `out_bit`. It appears one clock after the matching input bit, with `out_valid` high in that cycle.
- R6: While locked, each run of 10 consecutive plain ones restarts the hold timer, and so does every further one in the same run. Traffic that has such a run at least once every HOLD_TMO bits keeps `locked` high.
- R7: While locked, if HOLD_TMO accepted bits pass without a restart, `locked` falls on the edge that accepts the last of them.
- R8: On any clock edge where `clk_det` or `sig_det` is low, the block drops to sample mode and clears its ones count. `locked` reads 0 after that edge and cannot rise while either input stays low.
- R9: In mode 2'b11 `out_bit` equals the `in_bit` accepted on the previous edge.
- R10: When `in_valid` is low, nothing advances: `out_valid` is 0 on the next cycle and `out_bit` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Coding select (see R2) |
| clk_det | input | 1 | Receive clock present |
| sig_det | input | 1 | Line signal present |
| in_valid | input | 1 | `in_bit` holds a line bit this cycle |
| in_bit | input | 1 | Scrambled line bit |
| out_valid | output | 1 | `out_bit` holds a new bit |
| out_bit | output | 1 | Descrambled bit in the selected output coding |
| locked | output | 1 | Hold mode active |

## Verification
Scrambled idle is sent after a single zero plain bit. The zero poisons the hypothesis at three points, which places the 50-ones threshold on an exact bit and separates an off-by-one count from a correct one. Periodic runs of ten ones are spaced inside the timeout, and data with no such runs is sent after it. Together these separate retriggering from expiry, and the expiry is checked on the exact bit. All-zero and `11000` streams check that nothing but idle can lock. The NRZI and transparent modes, detect drops and gaps in `in_valid` are compared bit for bit with a behavioural model and with the plain data the bench scrambled itself.

// File: rtl/idle_lock_descrambler.sv
module idle_lock_descrambler #(
  parameter int LFSR_LEN = 11,
  parameter int TAP_NEAR = 9,
  parameter int TAP_FAR  = 11,
  parameter int ACQ_BITS = 50,
  parameter int RUN_BITS = 10,
  parameter int HOLD_TMO = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       clk_det,
  input  logic       sig_det,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       out_valid,
  output logic       out_bit,
  output logic       locked
);
  localparam int CNT_MAX = (ACQ_BITS > RUN_BITS) ? ACQ_BITS : RUN_BITS;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int TW = $clog2(HOLD_TMO + 1);
  localparam logic [CW-1:0] ACQ_LIM = CW'(ACQ_BITS);
  localparam logic [CW-1:0] RUN_LIM = CW'(RUN_BITS);
  localparam logic [TW-1:0] TMO_LD  = TW'(HOLD_TMO);

  logic [LFSR_LEN-1:0] hyp_sr, trk_sr;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;
  logic line_prev;

  wire line_nrzi   = (mode == 2'b00);
  wire out_nrzi    = ~mode[1];
  wire transparent = &mode;
  wire det_ok      = clk_det & sig_det;

  wire nrz    = line_nrzi ? (in_bit ^ line_prev) : in_bit;
  wire pred   = hyp_sr[TAP_NEAR-1] ^ hyp_sr[TAP_FAR-1];
  wire hyp    = nrz ^ pred;
  wire trk_fb = trk_sr[TAP_NEAR-1] ^ trk_sr[TAP_FAR-1];
  wire plain  = nrz ^ trk_fb;
  wire trk_in = locked ? ~trk_fb : nrz;

  wire            run_bit = locked ? plain : hyp;
  wire [CW-1:0]   run_lim = locked ? RUN_LIM : ACQ_LIM;
  logic [CW-1:0]  cnt_nxt;
  always_comb begin
    if (!run_bit)            cnt_nxt = '0;
    else if (cnt >= run_lim) cnt_nxt = run_lim;
    else                     cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hyp_sr    <= '0;
      trk_sr    <= '0;
      line_prev <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        line_prev <= in_bit;
        hyp_sr    <= {hyp_sr[LFSR_LEN-2:0], nrz};
        trk_sr    <= {trk_sr[LFSR_LEN-2:0], trk_in};
        if (transparent)   out_bit <= in_bit;
        else if (out_nrzi) out_bit <= out_bit ^ plain;
        else               out_bit <= plain;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !det_ok) begin
      locked <= 1'b0;
      cnt    <= '0;
      tmr    <= '0;
    end else if (in_valid) begin
      if (!locked) begin
        if (cnt_nxt == ACQ_LIM) begin
          locked <= 1'b1;
          cnt    <= '0;
          tmr    <= TMO_LD;
        end else begin
          cnt <= cnt_nxt;
        end
      end else begin
        cnt <= cnt_nxt;
        if (cnt_nxt == RUN_LIM) begin
          tmr <= TMO_LD;
        end else if (tmr <= TW'(1)) begin
          locked <= 1'b0;
          cnt    <= '0;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/idle_lock_descrambler_chk.sv
module idle_lock_descrambler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       clk_det,
  input logic       sig_det,
  input logic       in_valid,
  input logic       in_bit,
  input logic       out_valid,
  input logic       out_bit,
  input logic       locked
);
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_bit)));
  a_r8_detect_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_det && sig_det) |=> !locked);
  a_r3_lock_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(in_valid) && $past(clk_det && sig_det)));
  a_r7_no_loss_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !in_valid && clk_det && sig_det) |=> locked);
  a_r9_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=> (out_bit == $past(in_bit)));
  always @(posedge clk)
    if (rst_n && $past(!rst_n)) a_r1_reset_clear: assert (!locked && !out_valid && !out_bit);
endmodule

bind idle_lock_descrambler idle_lock_descrambler_chk u_chk (.*);

// File: tb/tb_idle_lock_descrambler.sv
module tb_idle_lock_descrambler;
  localparam int ACQ = 50, RUN = 10, TMO = 40;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b10;
  logic clk_det = 1, sig_det = 1, in_valid = 0, in_bit = 0;
  logic out_valid, out_bit, locked;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  idle_lock_descrambler #(.HOLD_TMO(TMO)) dut (.*);
  always #5 clk = ~clk;

  // behavioural reference
  bit mh[$], mt[$], lq[$];
  int mcnt, mtmr;
  bit mlock, mout, mval, mlp, tx_prev, prev_out, last_ud;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time); end
  endtask

  task automatic m_reset();
    mh = {}; mt = {};
    for (int i = 0; i < 11; i++) begin mh.push_back(0); mt.push_back(0); end
    mcnt = 0; mtmr = 0; mlock = 0; mout = 0; mval = 0; mlp = 0; tx_prev = 0;
  endtask

  task automatic m_step(bit ib, bit iv);
    bit nrz, hyp, tf, plain, rb; int lim, nx; bit was;
    mval = iv; was = mlock;
    if (iv) begin
      nrz = (mode == 0) ? (ib ^ mlp) : ib;
      mlp = ib;
      hyp = nrz ^ mh[8] ^ mh[10];
      tf = mt[8] ^ mt[10];
      plain = nrz ^ tf;
      mh.push_front(nrz); void'(mh.pop_back());
      mt.push_front(was ? !tf : nrz); void'(mt.pop_back());
      if (mode == 3) mout = ib; else if (mode < 2) mout = mout ^ plain; else mout = plain;
      rb = was ? plain : hyp; lim = was ? RUN : ACQ;
      nx = rb ? ((mcnt >= lim) ? lim : mcnt + 1) : 0;
    end
    if (!(clk_det && sig_det)) begin mlock = 0; mcnt = 0; mtmr = 0; end
    else if (iv) begin
      if (!was) begin
        if (nx == ACQ) begin mlock = 1; mcnt = 0; mtmr = TMO; end else mcnt = nx;
      end else begin
        mcnt = nx;
        if (nx == RUN) mtmr = TMO;
        else if (mtmr <= 1) begin mlock = 0; mcnt = 0; end
        else mtmr--;
      end
    end
  endtask

  task automatic drive(bit ib, bit iv);
    in_bit = ib; in_valid = iv;
    m_step(ib, iv);
    prev_out = out_bit;
    @(negedge clk);
    chk(out_valid == mval, "R10 model out_valid", out_valid, mval);
    chk(locked == mlock, "R3 model locked", locked, mlock);
    chk(out_bit == mout, "R2 model out_bit", out_bit, mout);
  endtask

  task automatic tx(bit ud);
    bit lds, sd, line;
    lds = lq[8] ^ lq[10];
    lq.push_front(lds); void'(lq.pop_back());
    sd = ud ^ lds;
    line = (mode == 0) ? (tx_prev ^ sd) : sd;
    tx_prev = line;
    last_ud = ud;
    drive(line, 1);
  endtask

  task automatic tx_plain_chk(bit ud, string req);
    bit got;
    tx(ud);
    got = (mode < 2) ? (out_bit ^ prev_out) : out_bit;
    chk(got == ud, req, got, ud);
  endtask

  task automatic do_reset(logic [1:0] m);
    @(negedge clk);
    rst_n = 0; in_valid = 0; mode = m; clk_det = 1; sig_det = 1;
    m_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 11; i++) lq.push_back(i % 3 == 0);
    m_reset();
    @(negedge clk); @(negedge clk);
    chk(!locked && !out_valid && !out_bit, "R1 in reset", {locked, out_valid, out_bit}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!locked && !out_valid && !out_bit, "R1 after reset", {locked, out_valid, out_bit}, 0);

    // R3: exact acquisition point
    for (int i = 0; i < 30; i++) tx(1);
    tx(0);
    for (int i = 0; i < 60; i++) tx(1);
    chk(locked == 0, "R3 one bit early", locked, 0);
    tx(1);
    chk(locked == 1, "R3 lock on 50th", locked, 1);

    // R5 + R7: data without runs, timeout on exact bit
    for (int i = 0; i < TMO - 1; i++) tx_plain_chk((i % 4) == 1 || (i % 4) == 2, "R5 data in hold");
    chk(locked == 1, "R7 before expiry", locked, 1);
    tx_plain_chk(0, "R5 last held bit");
    chk(locked == 0, "R7 expiry", locked, 0);

    // R6: periodic idle runs retrigger
    for (int i = 0; i < 80; i++) tx(1);
    chk(locked == 1, "R3 relock", locked, 1);
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 20; i++) tx_plain_chk(i % 2 == 0, "R5 mixed");
      for (int i = 0; i < 10; i++) tx_plain_chk(1, "R5 run");
    end
    chk(locked == 1, "R6 kept by runs", locked, 1);

    // R8/R10: detect drop in a gap
    sig_det = 0;
    drive(out_bit, 0);
    chk(locked == 0, "R8 detect drop", locked, 0);
    chk(out_valid == 0, "R10 gap invalid", out_valid, 0);
    chk(out_bit == prev_out, "R10 gap hold", out_bit, prev_out);
    for (int i = 0; i < 80; i++) tx(1);
    chk(locked == 0, "R8 no lock while low", locked, 0);
    sig_det = 1; clk_det = 0;
    tx(1);
    chk(locked == 0, "R8 clock detect low", locked, 0);
    clk_det = 1;

    // R4: non-idle streams
    do_reset(2'b10);
    for (int i = 0; i < 300; i++) tx(0);
    chk(locked == 0, "R4 quiet", locked, 0);
    for (int i = 0; i < 300; i++) tx(i % 5 < 2);
    chk(locked == 0, "R4 11000 pattern", locked, 0);

    // R2: NRZ line, NRZI output
    do_reset(2'b01);
    for (int i = 0; i < 80; i++) tx(1);
    chk(locked == 1, "R2 mode01 lock", locked, 1);
    for (int i = 0; i < 30; i++) tx_plain_chk(i % 3 == 0, "R2 mode01 data");

    // R2: NRZI both sides
    do_reset(2'b00);
    for (int i = 0; i < 80; i++) tx(1);
    chk(locked == 1, "R2 mode00 lock", locked, 1);
    for (int i = 0; i < 30; i++) tx_plain_chk(i % 3 != 1, "R2 mode00 data");

    // R9: transparent
    do_reset(2'b11);
    for (int i = 0; i < 30; i++) begin
      bit b = (i % 7) < 3;
      drive(b, 1);
      chk(out_bit == b, "R9 passthrough", out_bit, b);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule